// File: doc/BRIEF.md
# Bus Cycle Sequencer with Wait States

This block walks one processor bus transfer through its clock states: an address phase (T1), a command phase (T2), an optional run of wait states (TW), a data phase (T3) and a closing phase (T4). It models timing only. It produces no address and holds no data. It decodes the address-latch strobe, the active-low read and write strobes, the active-low data-buffer enable, the buffer direction and a one-clock completion pulse from the current state.

A slow target stretches a transfer by holding its ready line low. The ready line is asynchronous to the sequencer, so it first passes through a two-flop synchronizer. The synchronized value is sampled on the rising edge that closes T2. Inside every wait state, a second copy is captured on the falling clock edge, in the middle of the period, and that copy decides whether another wait state follows or the cycle moves on to T3.

A requester raises `req` together with the direction flag `rdWr` (1 = write). The request is taken on the edge that leaves idle, or on the edge that leaves T4, which allows back-to-back transfers.

Top module: `busSeq`

## Requirements
- R1: While `rstN` is low, `busState` is idle (code 0), `ale` and `cycleDone` are 0, and `rdN`, `wrN`, `denN` and `dtR` are 1.
- R2: State codes are idle=0, T1=1, T2=2, T3=3, T4=4, TW=5. A transfer whose synchronized ready is high at the end of T2 runs T1, T2, T3, T4 in exactly four clocks. At a 200 ns period this is 800 ns.
- R3: Wait states occur only between T2 and T3. T2 is followed only by T3 or TW, and TW only by TW or T3.
- R4: `readyAsync` passes through two flops before use. If it is held low from the request and raised at the falling edge inside T1, the transfer has exactly one wait state.
- R5: In each TW, the synchronized ready captured at that state's falling edge picks the next state. If `readyAsync` is raised at the falling edge of the j-th TW (j >= 1), the transfer has exactly j+2 wait states, one for each low sample.
- R6: `ale` is 1 in T1 and 0 in every other state.
- R7: `dtR` is 0 from T1 to T4 of a read and 1 for a write. It is 1 while idle.
- R8: `denN` is 0 in T2, TW and T3, and 1 otherwise.
- R9: For a read, `rdN` is 0 in T2, TW and T3. For a write, `wrN` is 0 in the same states. Both are 1 in T1 and T4, and they are never 0 together.
- R10: `cycleDone` is 1 for the single clock of T4 and 0 otherwise.
- R11: With `req` low, the sequencer stays idle with all strobes inactive, whatever `readyAsync` does. A request is taken only in idle or in T4, and the next state is T1.
- R12: The direction is latched when a request is taken. A change on `rdWr` during the transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; states change on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request for a bus transfer |
| rdWr | input | 1 | Direction of the requested transfer, 1 = write |
| readyAsync | input | 1 | Asynchronous ready from the target, low requests wait states |
| busState | output | 3 | Current state code (see R2) |
| ale | output | 1 | Address-latch strobe |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| denN | output | 1 | Active-low data-buffer enable |
| dtR | output | 1 | Buffer direction, 0 = toward the processor |
| cycleDone | output | 1 | One-clock pulse in T4 |

## Verification
The bound checker watches, on every clock, the legal state successions, that the idle state holds without a request, that the strobes never overlap and always lie inside the buffer-enable window, that the completion pulse never repeats, and that the direction stays steady from T2 to T4. Only the bench's scenarios can show the wait-state count, because it depends on when ready rises relative to the two-flop latency and the mid-period sample. The same holds for the exact per-state strobe values of reads and writes, for back-to-back acceptance from T4 and for ready being ignored while idle.

// File: rtl/busSeqPkg.sv
package busSeqPkg;
  typedef enum logic [2:0] {
    BS_IDLE = 3'd0,
    BS_T1   = 3'd1,
    BS_T2   = 3'd2,
    BS_T3   = 3'd3,
    BS_T4   = 3'd4,
    BS_TW   = 3'd5
  } busState_e;

  localparam int STATE_W = $bits(busState_e);

  // strobes from control to datapath
  typedef struct packed {
    logic latchDir;   // take direction on this edge
    logic addrPhase;  // T1
    logic xferOn;     // command strobe window
    logic bufOn;      // data buffer window
    logic dirOn;      // direction driven
    logic lastT;      // T4
  } seqStrobe_t;
endpackage

// File: rtl/busSeqSync.sv
module busSeqSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
    end
  endgenerate

  assign syncOut = chain[LAST];
endmodule

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       readySync,
  output busState_e  state,
  output seqStrobe_t strobe
);
  busState_e nextState;
  logic      readyMid;
  logic      takeReq;

  // mid-period sample used inside wait states
  always_ff @(negedge clk or negedge rstN)
    if (!rstN) readyMid <= 1'b0;
    else       readyMid <= readySync;

  assign takeReq = req && (state == BS_IDLE || state == BS_T4);

  always_comb begin
    nextState = state;
    unique case (state)
      BS_IDLE: nextState = req ? BS_T1 : BS_IDLE;
      BS_T1:   nextState = BS_T2;
      BS_T2:   nextState = readySync ? BS_T3 : BS_TW;
      BS_TW:   nextState = readyMid ? BS_T3 : BS_TW;
      BS_T3:   nextState = BS_T4;
      BS_T4:   nextState = req ? BS_T1 : BS_IDLE;
      default: nextState = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) state <= BS_IDLE;
    else       state <= nextState;

  always_comb begin
    strobe.latchDir  = takeReq;
    strobe.addrPhase = (state == BS_T1);
    strobe.xferOn    = (state == BS_T2) || (state == BS_TW) || (state == BS_T3);
    strobe.bufOn     = (state == BS_T2) || (state == BS_TW) || (state == BS_T3);
    strobe.dirOn     = (state != BS_IDLE);
    strobe.lastT     = (state == BS_T4);
  end
endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdWr,
  input  seqStrobe_t strobe,
  output logic       ale,
  output logic       rdN,
  output logic       wrN,
  output logic       denN,
  output logic       dtR,
  output logic       cycleDone
);
  logic dirWrite;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                dirWrite <= 1'b1;
    else if (strobe.latchDir) dirWrite <= rdWr;

  assign ale       = strobe.addrPhase;
  assign rdN       = !(strobe.xferOn && !dirWrite);
  assign wrN       = !(strobe.xferOn && dirWrite);
  assign denN      = !strobe.bufOn;
  assign dtR       = strobe.dirOn ? dirWrite : 1'b1;
  assign cycleDone = strobe.lastT;
endmodule

// File: rtl/busSeq.sv
module busSeq
  import busSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               req,
  input  logic               rdWr,
  input  logic               readyAsync,
  output logic [STATE_W-1:0] busState,
  output logic               ale,
  output logic               rdN,
  output logic               wrN,
  output logic               denN,
  output logic               dtR,
  output logic               cycleDone
);
  logic       readySync;
  busState_e  state;
  seqStrobe_t strobe;

  busSeqSync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(readyAsync), .syncOut(readySync)
  );

  busSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .readySync(readySync),
    .state(state), .strobe(strobe)
  );

  busSeqDatapath u_dp (
    .clk(clk), .rstN(rstN), .rdWr(rdWr), .strobe(strobe),
    .ale(ale), .rdN(rdN), .wrN(wrN), .denN(denN), .dtR(dtR),
    .cycleDone(cycleDone)
  );

  assign busState = state;
endmodule

// File: rtl/busSeqChecker.sv
module busSeqChecker
  import busSeqPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               req,
  input logic [STATE_W-1:0] busState,
  input logic               rdN,
  input logic               wrN,
  input logic               denN,
  input logic               dtR,
  input logic               cycleDone
);
  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rstN)
    busState == BS_T1 |=> busState == BS_T2);  // R2
  AST_T3_TO_T4: assert property (@(posedge clk) disable iff (!rstN)
    busState == BS_T3 |=> busState == BS_T4);  // R2
  AST_T2_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    busState == BS_T2 |=> (busState == BS_T3 || busState == BS_TW));  // R3
  AST_TW_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    busState == BS_TW |=> (busState == BS_T3 || busState == BS_TW));  // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));  // R9
  AST_STROBE_IN_DEN: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !denN);  // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);  // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BS_IDLE && !req) |=> busState == BS_IDLE);  // R11
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busState == BS_T2 || busState == BS_TW || busState == BS_T3 || busState == BS_T4)
      |-> $stable(dtR));  // R12
endmodule

bind busSeq busSeqChecker u_busSeqChecker (
  .clk(clk), .rstN(rstN), .req(req), .busState(busState), .rdN(rdN),
  .wrN(wrN), .denN(denN), .dtR(dtR), .cycleDone(cycleDone)
);

// File: tb/busSeq_bench.sv
module busSeq_bench;
  localparam time HALF = 10ns;  // 50 MHz
  localparam logic [2:0] S_IDLE = 3'd0, S_T1 = 3'd1, S_T2 = 3'd2,
                         S_T3 = 3'd3, S_T4 = 3'd4, S_TW = 3'd5;

  typedef struct {
    logic [2:0] st;
    logic ale, rdN, wrN, denN, dtR, done;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0, req = 1'b0, rdWr = 1'b0, readyAsync = 1'b1;
  logic [2:0] busState;
  logic ale, rdN, wrN, denN, dtR, cycleDone;
  int nChecks = 0, nFail = 0;
  bit monOn = 1'b0;
  expItem_t expQ[$];

  always #HALF clk = ~clk;

  busSeq u_busSeq (
    .clk(clk), .rstN(rstN), .req(req), .rdWr(rdWr), .readyAsync(readyAsync),
    .busState(busState), .ale(ale), .rdN(rdN), .wrN(wrN), .denN(denN),
    .dtR(dtR), .cycleDone(cycleDone)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic expItem_t mkItem(input logic [2:0] st, input logic wr);
    expItem_t it;
    logic win;
    win     = (st == S_T2) || (st == S_TW) || (st == S_T3);
    it.st   = st;
    it.ale  = (st == S_T1);
    it.dtR  = wr;
    it.denN = !win;
    it.rdN  = !(win && !wr);
    it.wrN  = !(win && wr);
    it.done = (st == S_T4);
    return it;
  endfunction

  // monitor: compares each bus-cycle state against the scoreboard
  always @(negedge clk) begin
    if (monOn) begin
      if (busState != S_IDLE) begin
        if (expQ.size() == 0) chk(1'b0, "R11 unexpected cycle state", busState, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(busState == e.st, "R3 state", busState, e.st);
          chk(ale == e.ale, "R6 ale", ale, e.ale);
          chk(dtR == e.dtR, "R7 dtR", dtR, e.dtR);
          chk(denN == e.denN, "R8 denN", denN, e.denN);
          chk(rdN == e.rdN, "R9 rdN", rdN, e.rdN);
          chk(wrN == e.wrN, "R9 wrN", wrN, e.wrN);
          chk(cycleDone == e.done, "R10 cycleDone", cycleDone, e.done);
        end
      end else begin
        chk({ale, rdN, wrN, denN, dtR, cycleDone} == 6'b011110,
            "R11 idle outputs", {ale, rdN, wrN, denN, dtR, cycleDone}, 6'b011110);
      end
    end
  end

  // rdyPlan: -1 ready high, 0 raised in T1, j>0 raised in j-th TW
  task automatic runCycle(input logic wr, input int rdyPlan, input bit holdReq, input string tag);
    int waits, tw, cyc;
    bit seenT1;
    waits = (rdyPlan < 0) ? 0 : (rdyPlan == 0) ? 1 : rdyPlan + 2;
    expQ.push_back(mkItem(S_T1, wr));
    expQ.push_back(mkItem(S_T2, wr));
    for (int i = 0; i < waits; i++) expQ.push_back(mkItem(S_TW, wr));
    expQ.push_back(mkItem(S_T3, wr));
    expQ.push_back(mkItem(S_T4, wr));
    rdWr = wr;
    readyAsync = (rdyPlan < 0);
    req = 1'b1;
    tw = 0; cyc = 0; seenT1 = 1'b0;
    forever begin
      @(negedge clk);
      if (busState == S_T1 && !seenT1) begin
        seenT1 = 1'b1;
        if (!holdReq) req = 1'b0;
        if (rdyPlan == 0) readyAsync = 1'b1;
      end
      if (seenT1) cyc++;
      if (busState == S_T2) rdWr = ~wr;  // R12: late change must be ignored
      if (busState == S_TW) begin
        tw++;
        if (tw == rdyPlan) readyAsync = 1'b1;
      end
      if (busState == S_T4 && seenT1) break;
    end
    readyAsync = 1'b1;
    chk(cyc == 4 + waits, {tag, " cycle length"}, cyc, 4 + waits);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(busState == S_IDLE, "R1 reset state", busState, S_IDLE);
    chk({ale, rdN, wrN, denN, dtR, cycleDone} == 6'b011110, "R1 reset outputs",
        {ale, rdN, wrN, denN, dtR, cycleDone}, 6'b011110);
    rstN = 1'b1;
    monOn = 1'b1;
    // R11: idle with ready toggling
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      readyAsync = ~readyAsync;
    end
    readyAsync = 1'b1;
    repeat (3) @(negedge clk);
    runCycle(1'b0, -1, 1'b0, "R2 read no wait");
    repeat (3) @(negedge clk);
    runCycle(1'b1, -1, 1'b0, "R2 write no wait");
    repeat (3) @(negedge clk);
    runCycle(1'b0, 0, 1'b0, "R4 read ready in T1");
    repeat (3) @(negedge clk);
    runCycle(1'b1, 1, 1'b0, "R5 write ready in TW1");
    repeat (3) @(negedge clk);
    runCycle(1'b0, 3, 1'b0, "R5 read ready in TW3");
    repeat (3) @(negedge clk);
    // back-to-back: second request taken at the end of T4
    runCycle(1'b1, -1, 1'b1, "R11 first of pair");
    runCycle(1'b0, 2, 1'b0, "R11 second of pair");
    repeat (4) @(negedge clk);
    chk(busState == S_IDLE, "R11 returns idle", busState, S_IDLE);
    chk(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule